// File: doc/BRIEF.md
# Priority-Based Exception Mask Unit

This unit keeps the three masking registers of a small microcontroller core. The first is a one-bit global mask. The second is a one-bit fault mask. The third is a base-priority threshold whose stored width is set by a parameter. From these registers, the priority of the handler now running and the priority of one pending exception, it works out the effective (boosted) priority. It also decides, in the same cycle, whether the pending exception may preempt.

Privileged software reaches the registers through a small select/write/read port and through dedicated set and clear commands for the two mask bits. The core pulses an exception-return strobe on every handler exit, and that strobe drops the fault mask. The decision path is purely combinational and is recomputed every cycle. No payload passes through the block, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

Priorities are compared as a 9-bit rank, in which a smaller rank is more urgent:
- rank 0 is NMI.
- rank 1 is HardFault.
- a programmable priority p (0..255) has rank p+2.
- thread mode, with no handler active, has rank 258.

Top module: `excmask_unit`

## Requirements
- R1: After reset the global mask, the fault mask and the base-priority register are all zero. With thread mode current, the effective rank is then 258.
- R2: When priv is 0, register writes and all four mask commands have no effect, and reg_rdata reads 0. The exception-return clear is the only exception to this rule.
- R3: Register select codes are fixed. Code 0 is the global mask in bit 0. Code 1 is the fault mask in bit 0. Code 2 is the base priority in bits 7:0. Code 3 reads 0 and ignores writes. Bits that are not implemented read 0.
- R4: Handler type is coded as 0 thread, 1 programmable, 2 HardFault and 3 NMI. eff_rank is the minimum of four candidates:
  - the current handler rank;
  - base+2, when the base register is nonzero;
  - 2, when the global mask is set;
  - 1, when the fault mask is set.
- R5: take is 1 exactly when pend_valid is 1 and the rank of the pending exception is strictly less than eff_rank.
- R6: With the global mask set, no programmable exception is taken, but HardFault and NMI still are.
- R7: With the fault mask set, HardFault is also blocked and only NMI is taken.
- R8: A nonzero base value blocks programmable priorities equal to or greater than it. A base value of zero blocks nothing.
- R9: Only the top PRIO_BITS bits of every priority are stored and compared; the lower bits are treated as zero. A base write of 0x7F therefore reads back as 0x60 when PRIO_BITS is 3.
- R10: An exception-return strobe clears the fault mask and leaves the global mask and the base register unchanged. It wins over a write or set command that arrives in the same cycle.
- R11: While the current handler type is HardFault or NMI, an attempt to set the fault mask is ignored. This covers both the set command and a write of 1. Clearing the fault mask still works.
- R12: A set command raises its mask bit and a clear command drops it. When both arrive together, clear wins; a command also wins over a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv | input | 1 | Current access is privileged |
| reg_sel | input | 2 | Register select (0 global, 1 fault, 2 base, 3 none) |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| gm_set | input | 1 | Set global mask command |
| gm_clr | input | 1 | Clear global mask command |
| fm_set | input | 1 | Set fault mask command |
| fm_clr | input | 1 | Clear fault mask command |
| exc_ret | input | 1 | Exception-return strobe |
| cur_type | input | 2 | Current handler type |
| cur_prio | input | 8 | Current handler priority (type 1 only) |
| pend_valid | input | 1 | A pending exception is presented |
| pend_type | input | 2 | Pending exception type |
| pend_prio | input | 8 | Pending exception priority (type 1 only) |
| take | output | 1 | Pending exception may preempt |
| eff_rank | output | 9 | Effective boosted priority rank |

## Verification
A wrong mask bit or a wrong base value shows at the ports in the same cycle, on eff_rank and take. It also appears on reg_rdata once the register is selected with privilege, one cycle after the register edge that stored it. A fault mask that survives an exception return is visible as eff_rank 1 right after the strobe. A bit set wrongly inside a top-level handler shows in the same way, and both can be read back on the next cycle. A bad rank encoding or a bad comparison shows at once on take, at the boundary where the pending rank equals the effective rank.

// File: rtl/excmask_pkg.sv
package excmask_pkg;
  localparam int FIELD_W = 8;
  localparam int RANK_W  = 9;

  typedef enum logic [1:0] {
    HT_THREAD    = 2'd0,
    HT_PROG      = 2'd1,
    HT_HARDFAULT = 2'd2,
    HT_NMI       = 2'd3
  } htype_e;

  typedef enum logic [1:0] {
    SEL_GLOBAL = 2'd0,
    SEL_FAULT  = 2'd1,
    SEL_BASE   = 2'd2,
    SEL_NONE   = 2'd3
  } regsel_e;

  localparam logic [RANK_W-1:0] RANK_NMI   = 9'd0;
  localparam logic [RANK_W-1:0] RANK_HF    = 9'd1;
  localparam logic [RANK_W-1:0] RANK_PROG0 = 9'd2;
  localparam logic [RANK_W-1:0] RANK_IDLE  = 9'd258;

  // Keep the upper pb bits of an 8-bit priority field.
  function automatic logic [FIELD_W-1:0] prio_mask(input int pb);
    logic [FIELD_W-1:0] m;
    m = '1;
    m = m << (FIELD_W - pb);
    return m;
  endfunction
endpackage

// File: rtl/excmask_rank.sv
module excmask_rank
  import excmask_pkg::*;
#(
  parameter int PRIO_BITS = 3
) (
  input  logic [1:0]         htype,
  input  logic [FIELD_W-1:0] prio,
  output logic [RANK_W-1:0]  rank
);
  localparam logic [FIELD_W-1:0] MASK = prio_mask(PRIO_BITS);

  logic [FIELD_W-1:0] prio_m;
  assign prio_m = prio & MASK;

  always_comb begin
    unique case (htype_e'(htype))
      HT_NMI:       rank = RANK_NMI;
      HT_HARDFAULT: rank = RANK_HF;
      HT_PROG:      rank = {1'b0, prio_m} + RANK_PROG0;
      default:      rank = RANK_IDLE;
    endcase
  end
endmodule

// File: rtl/excmask_boost.sv
module excmask_boost
  import excmask_pkg::*;
(
  input  logic [RANK_W-1:0]  cur_rank,
  input  logic               gm,
  input  logic               fm,
  input  logic [FIELD_W-1:0] base,
  input  logic               pend_valid,
  input  logic [RANK_W-1:0]  pend_rank,
  output logic [RANK_W-1:0]  eff_rank,
  output logic               take
);
  localparam int NCAND = 4;

  logic [RANK_W-1:0] cand [NCAND];
  logic              cen  [NCAND];

  assign cand[0] = cur_rank;
  assign cen[0]  = 1'b1;
  assign cand[1] = {1'b0, base} + RANK_PROG0;
  assign cen[1]  = (base != '0);
  assign cand[2] = RANK_PROG0;
  assign cen[2]  = gm;
  assign cand[3] = RANK_HF;
  assign cen[3]  = fm;

  // Minimum over the enabled candidates.
  logic [RANK_W-1:0] run [NCAND+1];
  assign run[0] = RANK_IDLE;
  for (genvar i = 0; i < NCAND; i++) begin : g_min
    assign run[i+1] = (cen[i] && cand[i] < run[i]) ? cand[i] : run[i];
  end

  assign eff_rank = run[NCAND];
  assign take     = pend_valid && (pend_rank < eff_rank);
endmodule

// File: rtl/excmask_regs.sv
module excmask_regs
  import excmask_pkg::*;
#(
  parameter int PRIO_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               priv,
  input  logic [1:0]         reg_sel,
  input  logic               reg_we,
  input  logic [FIELD_W-1:0] reg_wdata,
  output logic [FIELD_W-1:0] reg_rdata,
  input  logic               gm_set,
  input  logic               gm_clr,
  input  logic               fm_set,
  input  logic               fm_clr,
  input  logic               exc_ret,
  input  logic [1:0]         cur_type,
  output logic               gm_q,
  output logic               fm_q,
  output logic [FIELD_W-1:0] base_q
);
  localparam logic [FIELD_W-1:0] MASK = prio_mask(PRIO_BITS);

  logic wr_gm, wr_fm, wr_base, in_top, fm_set_ok;
  logic gm_d, fm_d;
  logic [FIELD_W-1:0] base_d;

  assign wr_gm   = priv && reg_we && (regsel_e'(reg_sel) == SEL_GLOBAL);
  assign wr_fm   = priv && reg_we && (regsel_e'(reg_sel) == SEL_FAULT);
  assign wr_base = priv && reg_we && (regsel_e'(reg_sel) == SEL_BASE);
  assign in_top  = (htype_e'(cur_type) == HT_HARDFAULT) || (htype_e'(cur_type) == HT_NMI);
  assign fm_set_ok = !in_top;

  always_comb begin
    gm_d = gm_q;
    if (priv && gm_clr)      gm_d = 1'b0;
    else if (priv && gm_set) gm_d = 1'b1;
    else if (wr_gm)          gm_d = reg_wdata[0];
  end

  always_comb begin
    fm_d = fm_q;
    if (exc_ret)                         fm_d = 1'b0;
    else if (priv && fm_clr)             fm_d = 1'b0;
    else if (priv && fm_set)             fm_d = fm_set_ok ? 1'b1 : fm_q;
    else if (wr_fm) begin
      if (!reg_wdata[0] || fm_set_ok)    fm_d = reg_wdata[0];
    end
  end

  always_comb begin
    base_d = base_q;
    if (wr_base) base_d = reg_wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gm_q   <= 1'b0;
      fm_q   <= 1'b0;
      base_q <= '0;
    end else begin
      gm_q   <= gm_d;
      fm_q   <= fm_d;
      base_q <= base_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (priv) begin
      unique case (regsel_e'(reg_sel))
        SEL_GLOBAL: reg_rdata = {{(FIELD_W-1){1'b0}}, gm_q};
        SEL_FAULT:  reg_rdata = {{(FIELD_W-1){1'b0}}, fm_q};
        SEL_BASE:   reg_rdata = base_q;
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/excmask_unit.sv
module excmask_unit
  import excmask_pkg::*;
#(
  parameter int PRIO_BITS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        priv,
  input  logic [1:0]  reg_sel,
  input  logic        reg_we,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        gm_set,
  input  logic        gm_clr,
  input  logic        fm_set,
  input  logic        fm_clr,
  input  logic        exc_ret,
  input  logic [1:0]  cur_type,
  input  logic [7:0]  cur_prio,
  input  logic        pend_valid,
  input  logic [1:0]  pend_type,
  input  logic [7:0]  pend_prio,
  output logic        take,
  output logic [8:0]  eff_rank
);
  logic               gm_q, fm_q;
  logic [FIELD_W-1:0] base_q;
  logic [RANK_W-1:0]  cur_rank, pend_rank;

  excmask_regs #(.PRIO_BITS(PRIO_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .priv(priv),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gm_set(gm_set), .gm_clr(gm_clr), .fm_set(fm_set), .fm_clr(fm_clr),
    .exc_ret(exc_ret), .cur_type(cur_type),
    .gm_q(gm_q), .fm_q(fm_q), .base_q(base_q)
  );

  excmask_rank #(.PRIO_BITS(PRIO_BITS)) u_cur_rank (
    .htype(cur_type), .prio(cur_prio), .rank(cur_rank)
  );

  excmask_rank #(.PRIO_BITS(PRIO_BITS)) u_pend_rank (
    .htype(pend_type), .prio(pend_prio), .rank(pend_rank)
  );

  excmask_boost u_boost (
    .cur_rank(cur_rank), .gm(gm_q), .fm(fm_q), .base(base_q),
    .pend_valid(pend_valid), .pend_rank(pend_rank),
    .eff_rank(eff_rank), .take(take)
  );
endmodule

// File: rtl/excmask_chk.sv
module excmask_chk
  import excmask_pkg::*;
#(
  parameter int PRIO_BITS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               priv,
  input logic               exc_ret,
  input logic [1:0]         cur_type,
  input logic [FIELD_W-1:0] reg_rdata,
  input logic               gm_q,
  input logic               fm_q,
  input logic [FIELD_W-1:0] base_q,
  input logic               pend_valid,
  input logic               take,
  input logic [RANK_W-1:0]  eff_rank
);
  localparam logic [FIELD_W-1:0] MASK = prio_mask(PRIO_BITS);

  AST_UNPRIV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !priv |-> reg_rdata == '0); // R2
  AST_UNPRIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv && !exc_ret) |=> ($stable(gm_q) && $stable(fm_q) && $stable(base_q))); // R2
  AST_RET_CLEARS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ret |=> !fm_q); // R10
  AST_RET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret && !priv) |=> ($stable(gm_q) && $stable(base_q))); // R10
  AST_TOP_NO_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!fm_q && cur_type[1]) |=> !fm_q); // R11
  AST_GLOBAL_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
    gm_q |-> eff_rank <= 9'd2); // R6
  AST_FAULT_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
    fm_q |-> eff_rank <= 9'd1); // R7
  AST_BASE_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q != '0) |-> eff_rank <= ({1'b0, base_q} + 9'd2)); // R8
  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q & ~MASK) == '0); // R9
  AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_valid); // R5
endmodule

bind excmask_unit excmask_chk #(.PRIO_BITS(PRIO_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv(priv), .exc_ret(exc_ret), .cur_type(cur_type),
  .reg_rdata(reg_rdata), .gm_q(gm_q), .fm_q(fm_q), .base_q(base_q),
  .pend_valid(pend_valid), .take(take), .eff_rank(eff_rank)
);

// File: tb/test_excmask_unit.sv
module test_excmask_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       priv = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       gm_set = 1'b0, gm_clr = 1'b0, fm_set = 1'b0, fm_clr = 1'b0;
  logic       exc_ret = 1'b0;
  logic [1:0] cur_type = 2'd0;
  logic [7:0] cur_prio = 8'h00;
  logic       pend_valid = 1'b0;
  logic [1:0] pend_type = 2'd0;
  logic [7:0] pend_prio = 8'h00;
  logic       take;
  logic [8:0] eff_rank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  excmask_unit #(.PRIO_BITS(3)) i_excmask_unit (
    .clk(clk), .rst_n(rst_n), .priv(priv), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gm_set(gm_set), .gm_clr(gm_clr),
    .fm_set(fm_set), .fm_clr(fm_clr), .exc_ret(exc_ret), .cur_type(cur_type),
    .cur_prio(cur_prio), .pend_valid(pend_valid), .pend_type(pend_type),
    .pend_prio(pend_prio), .take(take), .eff_rank(eff_rank)
  );

  typedef struct packed {
    logic       gm;
    logic       fm;
    logic [7:0] base;
    logic [1:0] ct;
    logic [7:0] cp;
    logic       pv;
    logic [1:0] pt;
    logic [7:0] pp;
    logic       exp_take;
    logic [8:0] exp_eff;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b0,8'h00,2'd0,8'h00,1'b1,2'd1,8'h40,1'b1,9'd258}, // thread mode
    '{1'b0,1'b0,8'h00,2'd1,8'h40,1'b1,2'd1,8'h40,1'b0,9'd66},  // equal rank
    '{1'b0,1'b0,8'h00,2'd1,8'h40,1'b1,2'd1,8'h20,1'b1,9'd66},
    '{1'b0,1'b0,8'h60,2'd0,8'h00,1'b1,2'd1,8'h60,1'b0,9'd98},  // R8 equal
    '{1'b0,1'b0,8'h60,2'd0,8'h00,1'b1,2'd1,8'h40,1'b1,9'd98},  // R8 more urgent
    '{1'b0,1'b0,8'h60,2'd1,8'h20,1'b1,2'd1,8'h40,1'b0,9'd34},
    '{1'b1,1'b0,8'h00,2'd0,8'h00,1'b1,2'd1,8'h00,1'b0,9'd2},   // R6 blocks prio 0
    '{1'b1,1'b0,8'h00,2'd0,8'h00,1'b1,2'd2,8'h00,1'b1,9'd2},   // R6 HardFault taken
    '{1'b0,1'b1,8'h00,2'd0,8'h00,1'b1,2'd2,8'h00,1'b0,9'd1},   // R7 HardFault blocked
    '{1'b0,1'b1,8'h00,2'd0,8'h00,1'b1,2'd3,8'h00,1'b1,9'd1},   // R7 NMI taken
    '{1'b0,1'b0,8'h00,2'd1,8'h40,1'b1,2'd1,8'h3F,1'b1,9'd66},  // R9 low bits dropped
    '{1'b0,1'b0,8'h7F,2'd0,8'h00,1'b1,2'd1,8'h5F,1'b1,9'd98},  // R9 base stored 0x60
    '{1'b0,1'b0,8'h00,2'd2,8'h00,1'b1,2'd1,8'h00,1'b0,9'd1},   // in HardFault
    '{1'b0,1'b0,8'h00,2'd3,8'h00,1'b1,2'd2,8'h00,1'b0,9'd0},   // in NMI
    '{1'b0,1'b0,8'h00,2'd0,8'h00,1'b0,2'd3,8'h00,1'b0,9'd258}, // nothing pending
    '{1'b1,1'b0,8'h20,2'd0,8'h00,1'b1,2'd2,8'h00,1'b1,9'd2}    // gm beats base
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] sel, input int exp);
    @(negedge clk);
    reg_sel = sel;
    #2;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic pulse(input logic gs, input logic gc, input logic fs, input logic fc,
                       input logic er);
    @(negedge clk);
    gm_set = gs; gm_clr = gc; fm_set = fs; fm_clr = fc; exc_ret = er;
    @(negedge clk);
    gm_set = 1'b0; gm_clr = 1'b0; fm_set = 1'b0; fm_clr = 1'b0; exc_ret = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 global", 2'd0, 0);
    rd("R1 fault", 2'd1, 0);
    rd("R1 base", 2'd2, 0);
    #1 chk("R1 eff thread", int'(eff_rank), 258);

    // Vector table: R4 effective rank, R5 decision
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      cur_type = 2'd1; cur_prio = 8'hE0; pend_valid = 1'b0;
      wr(2'd0, {7'd0, VEC[i].gm});
      wr(2'd1, {7'd0, VEC[i].fm});
      wr(2'd2, VEC[i].base);
      @(negedge clk);
      cur_type = VEC[i].ct; cur_prio = VEC[i].cp;
      pend_valid = VEC[i].pv; pend_type = VEC[i].pt; pend_prio = VEC[i].pp;
      #2;
      chk($sformatf("R5 take vec %0d", i), int'(take), int'(VEC[i].exp_take));
      chk($sformatf("R4 eff vec %0d", i), int'(eff_rank), int'(VEC[i].exp_eff));
    end
    @(negedge clk);
    cur_type = 2'd0; pend_valid = 1'b0;

    // R9 base read-back truncation
    wr(2'd2, 8'h7F);
    rd("R9 base readback", 2'd2, 8'h60);

    // R3 select code 3
    wr(2'd0, 8'h00);
    wr(2'd3, 8'hFF);
    rd("R3 sel3 reads zero", 2'd3, 0);
    rd("R3 sel3 write no effect gm", 2'd0, 0);
    rd("R3 sel3 write no effect base", 2'd2, 8'h60);

    // R2 unprivileged access
    @(negedge clk); priv = 1'b0;
    rd("R2 unpriv read", 2'd2, 0);
    wr(2'd2, 8'h00);
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); priv = 1'b1;
    rd("R2 unpriv write dropped", 2'd2, 8'h60);
    rd("R2 unpriv gm_set dropped", 2'd0, 0);
    rd("R2 unpriv fm_set dropped", 2'd1, 0);

    // R12 commands
    pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    rd("R12 gm_set", 2'd0, 1);
    pulse(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    rd("R12 set+clr clears", 2'd0, 0);
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    rd("R12 fm_set", 2'd1, 1);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    rd("R12 fm_clr", 2'd1, 0);

    // R11 no fault-mask set inside top-level handlers
    @(negedge clk); cur_type = 2'd3;
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    rd("R11 set in NMI ignored", 2'd1, 0);
    @(negedge clk); cur_type = 2'd2;
    wr(2'd1, 8'h01);
    rd("R11 write in HardFault ignored", 2'd1, 0);
    @(negedge clk); cur_type = 2'd1;
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); cur_type = 2'd2;
    pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    rd("R11 clear in HardFault works", 2'd1, 0);

    // R10 exception return
    @(negedge clk); cur_type = 2'd0;
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    rd("R10 fm before return", 2'd1, 1);
    pulse(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    rd("R10 fm cleared", 2'd1, 0);
    rd("R10 gm kept", 2'd0, 1);
    rd("R10 base kept", 2'd2, 8'h60);
    @(negedge clk);
    reg_sel = 2'd1; reg_wdata = 8'h01; reg_we = 1'b1; exc_ret = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; exc_ret = 1'b0;
    rd("R10 return beats write", 2'd1, 0);
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    rd("R10 return beats set", 2'd1, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule